// File: doc/BRIEF.md
# Keyed Modulation Data Path Controller

This block turns a serial transmit bit stream into the two per-cycle controls that a fractional-N transmitter needs: a signed frequency offset for the divider and a 7-bit level code for the power amplifier. A 2-bit scheme field selects one of four keyings. The two frequency keyings (plain and Gaussian-shaped) move the offset up or down around the centre value. The two amplitude keyings leave the frequency alone and switch the amplifier between two levels, or between one level and off. A single 7-bit code field is reused: in the plain frequency keying it is the deviation, and in the two-level amplitude keying it is the level for a data 0.

All outputs advance on a phase-detector-rate clock enable. In the Gaussian-shaped scheme the block also generates a transmit clock for the data source. Its period is a divider factor times a power-of-two index count, counted in enabled cycles. The data bit is taken only on that clock's rising edge. In every other scheme the bit is taken on each enabled cycle. A data-invert control complements the bit before use.

Top module: `keyed_mod_ctrl`

## Requirements
- R1: During and after reset, until the first enabled cycle, freqOfs is 0, paLevel is 0 and txClk is 0.
- R2: The scheme code is 00 for plain frequency keying. In that scheme an enabled cycle sets freqOfs to +devCode for an effective bit of 1 and to -devCode for a bit of 0, in units of the phase-detector frequency divided by 4096.
- R3: In plain frequency keying with devCode equal to 0, freqOfs is 0 for either bit value. The carrier is left unmodulated.
- R4: The scheme code is 01 for Gaussian-shaped keying. There freqOfs is +2^shiftSel for an effective bit of 1 and -2^shiftSel for a bit of 0. In both frequency keyings paLevel follows pwrCode.
- R5: The scheme code is 10 for two-level amplitude keying. A bit of 1 puts pwrCode on paLevel and a bit of 0 puts devCode there. freqOfs is 0.
- R6: The scheme code is 11 for on/off keying. A bit of 1 puts pwrCode on paLevel and a bit of 0 gives paLevel 0. freqOfs is 0.
- R7: A level code's two MSBs (bits 6:5) select the range and its five LSBs select the step within it. A selected code whose range is 00 means amplifier off, so paLevel reads 0.
- R8: When dataInv is 1 the effective bit is the complement of txData.
- R9: Outputs are registered. They change only at a clock edge where pfdEn is 1, and that edge also reflects the inputs present at it. With pfdEn at 0 they hold.
- R10: In Gaussian-shaped keying with a nonzero divFactor, txClk rises at the first enabled edge. After that it has a period of divFactor × N enabled cycles and is high for half of it. N is 16, 32, 64 or 128 for indexSel 0, 1, 2 or 3.
- R11: In Gaussian-shaped keying the bit is sampled only at the edge where txClk rises. txData changes between those edges do not affect freqOfs.
- R12: txClk is held at 0 when divFactor is 0 or when the scheme is not Gaussian-shaped keying.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfdEn | input | 1 | Phase-detector-rate clock enable |
| cfgScheme | input | 2 | Keying scheme: 00 FSK, 01 Gaussian FSK, 10 two-level ASK, 11 OOK |
| devCode | input | 7 | Deviation in steps, or the data-0 level in two-level ASK |
| pwrCode | input | 7 | Amplifier level code for a data 1 and for the frequency keyings |
| dataInv | input | 1 | Complement the transmit bit |
| divFactor | input | 7 | Transmit clock divider factor; 0 stops the clock |
| indexSel | input | 2 | Index count select: 16, 32, 64 or 128 |
| shiftSel | input | 3 | Gaussian deviation exponent |
| txData | input | 1 | Transmit data bit |
| freqOfs | output | 9 | Signed fractional frequency offset in steps |
| paLevel | output | 7 | Amplifier level code |
| txClk | output | 1 | Transmit clock for the data source |

## Verification
The bench builds the block with its default widths: 7-bit codes, a 3-bit exponent and a 9-bit offset. With these, the extreme deviation code 127 and the exponent 7 (offset ±128) exercise the edges of the signed offset range. The Gaussian runs use divider factors 2 and 3 with index counts 16 and 32. That gives transmit clock periods of 32 and 96 cycles, so several full periods, the half-period high time and the first rise on entry all fall within a short run. Meanwhile txData is toggled randomly in every cycle between sampling edges.

// File: rtl/kmod_pkg.sv
package kmod_pkg;

  typedef enum logic [1:0] {
    MOD_FSK  = 2'b00,
    MOD_GFSK = 2'b01,
    MOD_ASK  = 2'b10,
    MOD_OOK  = 2'b11
  } modScheme_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic update;   // registers advance this cycle
    logic sample;   // take a new transmit bit this cycle
  } dpStrobe_t;

endpackage

// File: rtl/kmod_ctrl.sv
module kmod_ctrl
  import kmod_pkg::*;
#(
  parameter int DIVF_W        = 7,
  parameter int IDX_BASE_LOG2 = 4,
  parameter int IDX_SEL_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pfdEn,
  input  modScheme_e           scheme,
  input  logic [DIVF_W-1:0]    divFactor,
  input  logic [IDX_SEL_W-1:0] indexSel,
  output dpStrobe_t            strobe,
  output logic                 txClk
);

  localparam int SEL_MAX = (1 << IDX_SEL_W) - 1;
  localparam int IDX_W   = IDX_BASE_LOG2 + SEL_MAX;

  logic [DIVF_W-1:0] preCnt;
  logic [IDX_W-1:0]  idxCnt;
  logic              running;

  logic              clkOn;
  logic              preWrap;
  logic              idxWrap;
  logic [IDX_W-1:0]  idxLast;
  logic [IDX_W-1:0]  idxHalf;
  logic [IDX_W-1:0]  idxNext;

  always_comb begin
    clkOn   = (scheme == MOD_GFSK) && (divFactor != '0);
    idxLast = {IDX_W{1'b1}} >> (IDX_SEL_W'(SEL_MAX) - indexSel);
    idxHalf = (idxLast >> 1) + 1'b1;
    preWrap = preCnt >= (divFactor - 1'b1);
    idxWrap = idxCnt >= idxLast;
    if (preWrap) idxNext = idxWrap ? '0 : idxCnt + 1'b1;
    else         idxNext = idxCnt;

    strobe.update = pfdEn;
    if (scheme != MOD_GFSK) strobe.sample = pfdEn;
    else strobe.sample = clkOn && pfdEn && (!running || (preWrap && idxWrap));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      preCnt  <= '0;
      idxCnt  <= '0;
      txClk   <= 1'b0;
    end else if (!clkOn) begin
      running <= 1'b0;
      preCnt  <= '0;
      idxCnt  <= '0;
      txClk   <= 1'b0;
    end else if (pfdEn) begin
      if (!running) begin
        running <= 1'b1;
        preCnt  <= '0;
        idxCnt  <= '0;
        txClk   <= 1'b1;
      end else begin
        preCnt  <= preWrap ? '0 : preCnt + 1'b1;
        idxCnt  <= idxNext;
        txClk   <= idxNext < idxHalf;
      end
    end
  end

  // R12: the clock stays low when stopped or outside the Gaussian scheme
  p_idle_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (scheme != MOD_GFSK || divFactor == '0) |=> !txClk);

  // R11: a Gaussian-mode sample is always followed by a high clock
  p_rise_sample_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scheme == MOD_GFSK && strobe.sample) |=> txClk);

  // R10: the clock only rises where a sample was taken
  p_rise_on_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txClk) |-> $past(strobe.sample));

endmodule

// File: rtl/kmod_dp.sv
module kmod_dp
  import kmod_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int MC_W   = 3,
  parameter int OFS_W  = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  dpStrobe_t                strobe,
  input  modScheme_e               scheme,
  input  logic [CODE_W-1:0]        devCode,
  input  logic [CODE_W-1:0]        pwrCode,
  input  logic                     dataInv,
  input  logic [MC_W-1:0]          shiftSel,
  input  logic                     txData,
  output logic signed [OFS_W-1:0]  freqOfs,
  output logic [CODE_W-1:0]        paLevel
);

  localparam int RNG_W = 2;

  logic                    heldBit;
  logic                    bitNow;
  logic [OFS_W-1:0]        mag;
  logic signed [OFS_W-1:0] ofsNext;
  logic [CODE_W-1:0]       lvlPick;
  logic [CODE_W-1:0]       lvlNext;

  always_comb begin
    bitNow = strobe.sample ? (txData ^ dataInv) : heldBit;

    unique case (scheme)
      MOD_FSK:  mag = OFS_W'(devCode);
      MOD_GFSK: mag = OFS_W'(1) << shiftSel;
      default:  mag = '0;
    endcase
    ofsNext = bitNow ? $signed(mag) : -$signed(mag);

    unique case (scheme)
      MOD_ASK: lvlPick = bitNow ? pwrCode : devCode;
      MOD_OOK: lvlPick = bitNow ? pwrCode : '0;
      default: lvlPick = pwrCode;
    endcase
    lvlNext = (lvlPick[CODE_W-1 -: RNG_W] == '0) ? '0 : lvlPick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      heldBit <= 1'b0;
      freqOfs <= '0;
      paLevel <= '0;
    end else if (strobe.update) begin
      heldBit <= bitNow;
      freqOfs <= ofsNext;
      paLevel <= lvlNext;
    end
  end

  // R9: outputs hold without an update strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.update |=> ($stable(freqOfs) && $stable(paLevel)));

  // R3: zero deviation in plain frequency keying leaves the carrier
  p_fsk_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.update && scheme == MOD_FSK && devCode == '0) |=> (freqOfs == '0));

  // R5, R6: amplitude keyings never move the frequency
  p_amp_no_ofs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.update && (scheme == MOD_ASK || scheme == MOD_OOK)) |=> (freqOfs == '0));

  // R7: a level in range 00 is never driven out
  p_range_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (paLevel[CODE_W-1 -: RNG_W] != '0) || (paLevel == '0));

endmodule

// File: rtl/keyed_mod_ctrl.sv
module keyed_mod_ctrl
  import kmod_pkg::*;
#(
  parameter int CODE_W        = 7,
  parameter int MC_W          = 3,
  parameter int OFS_W         = 9,
  parameter int DIVF_W        = 7,
  parameter int IDX_BASE_LOG2 = 4,
  parameter int IDX_SEL_W     = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pfdEn,
  input  logic [1:0]               cfgScheme,
  input  logic [CODE_W-1:0]        devCode,
  input  logic [CODE_W-1:0]        pwrCode,
  input  logic                     dataInv,
  input  logic [DIVF_W-1:0]        divFactor,
  input  logic [IDX_SEL_W-1:0]     indexSel,
  input  logic [MC_W-1:0]          shiftSel,
  input  logic                     txData,
  output logic signed [OFS_W-1:0]  freqOfs,
  output logic [CODE_W-1:0]        paLevel,
  output logic                     txClk
);

  modScheme_e schemeE;
  dpStrobe_t  strobe;

  assign schemeE = modScheme_e'(cfgScheme);

  kmod_ctrl #(
    .DIVF_W(DIVF_W), .IDX_BASE_LOG2(IDX_BASE_LOG2), .IDX_SEL_W(IDX_SEL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pfdEn(pfdEn), .scheme(schemeE),
    .divFactor(divFactor), .indexSel(indexSel),
    .strobe(strobe), .txClk(txClk)
  );

  kmod_dp #(
    .CODE_W(CODE_W), .MC_W(MC_W), .OFS_W(OFS_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .scheme(schemeE),
    .devCode(devCode), .pwrCode(pwrCode), .dataInv(dataInv),
    .shiftSel(shiftSel), .txData(txData),
    .freqOfs(freqOfs), .paLevel(paLevel)
  );

endmodule

// File: tb/keyed_mod_ctrl_tb.sv
`timescale 1ns/1ps
module keyed_mod_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pfdEn;
  logic [1:0] cfgScheme;
  logic [6:0] devCode, pwrCode, divFactor;
  logic       dataInv, txData;
  logic [1:0] indexSel;
  logic [2:0] shiftSel;
  logic signed [8:0] freqOfs;
  logic [6:0] paLevel;
  logic       txClk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keyed_mod_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pfdEn(pfdEn), .cfgScheme(cfgScheme),
    .devCode(devCode), .pwrCode(pwrCode), .dataInv(dataInv),
    .divFactor(divFactor), .indexSel(indexSel), .shiftSel(shiftSel),
    .txData(txData), .freqOfs(freqOfs), .paLevel(paLevel), .txClk(txClk)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expOfs(int sch, int dev, int mc, bit b);
    case (sch)
      0: return b ? dev : -dev;
      1: return b ? (1 << mc) : -(1 << mc);
      default: return 0;
    endcase
  endfunction

  function automatic int expLvl(int sch, int dev, int pwr, bit b);
    int pick;
    case (sch)
      2: pick = b ? pwr : dev;
      3: pick = b ? pwr : 0;
      default: pick = pwr;
    endcase
    if ((pick >> 5) == 0) return 0;
    return pick;
  endfunction

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic applyOne(int sch, int dev, int pwr, bit inv, bit d, string tag);
    cfgScheme = 2'(sch); devCode = 7'(dev); pwrCode = 7'(pwr);
    dataInv = inv; txData = d; pfdEn = 1'b1;
    tick();
    chk(int'(freqOfs) == expOfs(sch, dev, 0, d ^ inv), {tag, " ofs"},
        int'(freqOfs), expOfs(sch, dev, 0, d ^ inv));
    chk(int'(paLevel) == expLvl(sch, dev, pwr, d ^ inv), {tag, " lvl"},
        int'(paLevel), expLvl(sch, dev, pwr, d ^ inv));
  endtask

  task automatic runGfsk(int div, int sel, int mc, bit inv, int pwr, int cycles);
    int period = div * (16 << sel);
    int rises = 0, sinceRise = 0, highCnt = 0;
    bit prevClk = 0, expBit = 0;
    cfgScheme = 2'd1; divFactor = 7'(div); indexSel = 2'(sel);
    shiftSel = 3'(mc); dataInv = inv; pwrCode = 7'(pwr); pfdEn = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      bit d = 1'($urandom % 2);
      txData = d;
      tick();
      if (c == 0) chk(txClk == 1'b1, "R10 first rise", int'(txClk), 1);
      if (txClk && !prevClk) begin
        if (rises > 0) begin
          chk(sinceRise == period, "R10 period", sinceRise, period);
          chk(highCnt == period / 2, "R10 high time", highCnt, period / 2);
        end
        rises++; sinceRise = 0; highCnt = 0; expBit = d ^ inv;
      end
      sinceRise++;
      if (txClk) highCnt++;
      if (rises > 0) begin
        chk(int'(freqOfs) == expOfs(1, 0, mc, expBit), "R11 R4 gfsk ofs",
            int'(freqOfs), expOfs(1, 0, mc, expBit));
        chk(int'(paLevel) == expLvl(1, 0, pwr, expBit), "R4 gfsk lvl",
            int'(paLevel), expLvl(1, 0, pwr, expBit));
      end
      prevClk = txClk;
    end
    chk(rises >= 2, "R10 rise count", rises, 2);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int eOfs, eLvl, lastOfs;
    void'($urandom(32'd2468));
    rst_n = 1'b0; pfdEn = 1'b0; cfgScheme = 2'd0; devCode = 7'd0; pwrCode = 7'd0;
    dataInv = 1'b0; divFactor = 7'd0; indexSel = 2'd0; shiftSel = 3'd0; txData = 1'b0;
    repeat (3) tick();
    chk(freqOfs == 0, "R1 reset ofs", int'(freqOfs), 0);
    chk(paLevel == 0, "R1 reset lvl", int'(paLevel), 0);
    chk(txClk == 0, "R1 reset clk", int'(txClk), 0);
    rst_n = 1'b1;
    tick();
    chk(freqOfs == 0 && paLevel == 0, "R1 idle after reset", int'(freqOfs), 0);

    // Directed corners
    applyOne(0, 5, 7'h45, 1'b0, 1'b1, "R2 fsk +");
    applyOne(0, 5, 7'h45, 1'b0, 1'b0, "R2 fsk -");
    applyOne(0, 127, 7'h7F, 1'b0, 1'b0, "R2 fsk max");
    applyOne(0, 0, 7'h45, 1'b0, 1'b1, "R3 zero dev 1");
    applyOne(0, 0, 7'h45, 1'b0, 1'b0, "R3 zero dev 0");
    applyOne(0, 5, 7'h45, 1'b1, 1'b1, "R8 invert fsk");
    applyOne(2, 7'h33, 7'h6A, 1'b0, 1'b1, "R5 ask one");
    applyOne(2, 7'h33, 7'h6A, 1'b0, 1'b0, "R5 ask zero");
    applyOne(2, 7'h1F, 7'h6A, 1'b1, 1'b1, "R8 R5 ask invert");
    applyOne(3, 7'h33, 7'h6A, 1'b0, 1'b1, "R6 ook one");
    applyOne(3, 7'h33, 7'h6A, 1'b0, 1'b0, "R6 ook off");
    applyOne(3, 7'h10, 7'h1F, 1'b0, 1'b1, "R7 range off");
    applyOne(2, 7'h1F, 7'h6A, 1'b0, 1'b0, "R7 ask range off");

    // Constrained random over the non-Gaussian schemes
    eOfs = int'(freqOfs); eLvl = int'(paLevel);
    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 3;
      int sch = (r == 0) ? 0 : r + 1;
      bit en = ($urandom % 4) != 0;
      bit inv = 1'($urandom % 2);
      bit d = 1'($urandom % 2);
      int dev = $urandom % 128;
      int pwr = $urandom % 128;
      cfgScheme = 2'(sch); devCode = 7'(dev); pwrCode = 7'(pwr);
      dataInv = inv; txData = d; pfdEn = en;
      divFactor = 7'($urandom % 128); indexSel = 2'($urandom % 4);
      tick();
      if (en) begin
        eOfs = expOfs(sch, dev, 0, d ^ inv);
        eLvl = expLvl(sch, dev, pwr, d ^ inv);
      end
      chk(int'(freqOfs) == eOfs, en ? "R2 R5 R6 random ofs" : "R9 hold ofs",
          int'(freqOfs), eOfs);
      chk(int'(paLevel) == eLvl, en ? "R5 R6 R7 random lvl" : "R9 hold lvl",
          int'(paLevel), eLvl);
      chk(txClk == 1'b0, "R12 clk low outside gfsk", int'(txClk), 0);
    end

    // Gaussian-shaped keying with the transmit clock
    runGfsk(2, 0, 3, 1'b0, 7'h55, 200);
    cfgScheme = 2'd0; pfdEn = 1'b1; tick();
    runGfsk(3, 1, 7, 1'b1, 7'h20, 400);

    // Stopped divider: clock low, no new samples
    divFactor = 7'd0;
    tick();
    lastOfs = int'(freqOfs);
    for (int i = 0; i < 40; i++) begin
      txData = 1'($urandom % 2);
      tick();
      chk(txClk == 1'b0, "R12 divider zero clk", int'(txClk), 0);
      chk(int'(freqOfs) == lastOfs, "R11 no sample when stopped", int'(freqOfs), lastOfs);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule